// File: doc/BRIEF.md
# Two-Channel Register-Driven Stream DMA

This engine moves word buffers between a word-addressed memory and two 32-bit streams. The send channel fetches words from memory and drives them out on an outgoing stream. It marks the final word of the programmed length. The receive channel takes words from an incoming stream and stores them at consecutive memory words. It stops at an end-of-packet marker or when the programmed length runs out, whichever comes first.

Software drives each channel through four registers: control, status, address and byte length. A channel must first be set running. Writing a length of at least four bytes to an idle, running channel starts one transfer from the address held in that channel's address register. Completion raises a sticky flag that software clears by writing a one to it. A self-clearing soft reset returns one channel to its halted, cleared state without disturbing the other. Software normally arms the receive channel before the send channel, so that the receive side is already accepting when stream data appears.

Each channel runs a sequencer with four states. HALTED goes to RUNNING on a run write, and to RESETTING on a soft-reset write. RUNNING goes to HALTED on a stop write while idle, to STOPPING on a stop write while a transfer is in flight, and to RESETTING on a soft-reset write. STOPPING goes to HALTED once the transfer ends, back to RUNNING on a run write, and to RESETTING on a soft-reset write. RESETTING goes to HALTED after a fixed count of cycles.

The send datapath has four states. IDLE goes to FETCH on launch. FETCH issues a memory read and goes to LOAD. LOAD captures the read word and goes to SEND. SEND waits for the stream handshake, then goes to FETCH, or to IDLE after the final word.

The receive datapath has two states. IDLE goes to ACCEPT on launch. ACCEPT writes one word per handshake and returns to IDLE on an end marker or on the final counted word.

Top module: `sdma_engine`

## Requirements
- R1: After reset, both status registers read 0x1 (halted), all other registers read 0, the outgoing stream valid is low and the incoming stream ready is low.
- R2: Registers sit at these byte offsets: send control 0x00, send status 0x04, send address 0x18, send length 0x28, receive control 0x30, receive status 0x34, receive address 0x48, receive length 0x58. A read request returns its data, with a read-valid strobe, one cycle later. Unmapped offsets read 0.
- R3: Control bit 0 is run/stop. Writing 1 clears status bit 0 (halted) on the next cycle. Writing 0 to an idle channel sets halted again, and also sets it for a busy channel once its transfer ends. Control bit 0 reads 1 only while the channel is running.
- R4: Writing control bit 2 starts a soft reset of that channel. Bit 2 reads 1 for RST_CYCLES cycles and then clears by itself. The channel ends halted, with its address, length and completion flag cleared. The other channel is unaffected.
- R5: A length write to a running, idle channel launches one transfer when the byte value in bits LW-1:2 is non-zero. The transfer moves length/4 words, starting at memory word address = address register / 4 and stepping by one word per transfer.
- R6: A length write while the channel is halted or busy has no effect. The length register keeps its old value and no transfer starts.
- R7: The send channel emits its words in memory order. tkeep is 4'b1111 on every word and tlast is high only on the final word. Data and tlast hold steady while valid waits for ready, and valid drops after the final word.
- R8: The receive channel raises ready only while a transfer is active. It writes each accepted word to the next memory word and stops after an accepted word that carries tlast or after the programmed word count, whichever comes first. Memory beyond that point is untouched.
- R9: Status bit 12 is set when a transfer completes and stays set until software writes 1 to it. If completion and such a write land in the same cycle, the flag stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_valid | input | 1 | Register access request, accepted every cycle |
| cfg_write | input | 1 | 1 = write, 0 = read |
| cfg_addr | input | REG_AW | Register byte offset |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Read data, valid with cfg_rvalid |
| cfg_rvalid | output | 1 | Read data strobe, one cycle after a read request |
| mem_rd_en | output | 1 | Memory read request |
| mem_rd_addr | output | AW-2 | Memory word address for reads |
| mem_rd_data | input | 32 | Read word, valid the cycle after mem_rd_en |
| mem_wr_en | output | 1 | Memory write strobe |
| mem_wr_addr | output | AW-2 | Memory word address for writes |
| mem_wr_data | output | 32 | Memory write word |
| m_tvalid | output | 1 | Outgoing stream valid |
| m_tready | input | 1 | Outgoing stream ready |
| m_tdata | output | 32 | Outgoing stream data |
| m_tlast | output | 1 | Outgoing final-word marker |
| m_tkeep | output | 4 | Outgoing byte keep, all ones |
| s_tvalid | input | 1 | Incoming stream valid |
| s_tready | output | 1 | Incoming stream ready |
| s_tdata | input | 32 | Incoming stream data |
| s_tlast | input | 1 | Incoming end-of-packet marker |

## Verification
Two events can meet in one cycle. A receive transfer can complete while software writes 1 to clear the completion flag. The bench provokes this by driving the final receive word and the status clear write on the same edge, with ready known high beforehand. It then reads the status and expects bit 12 still set; a second clear write must then drop it. Random ready stalls on the send side and random gaps on the receive side run alongside. Every word and marker is compared with values the bench computes from the programmed address and length.

// File: rtl/sdma_pkg.sv
package sdma_pkg;

    localparam int unsigned NUM_CH    = 2;
    localparam int unsigned CH_SEND   = 0;
    localparam int unsigned CH_RECV   = 1;
    localparam int unsigned CH_STRIDE = 'h30;

    localparam int unsigned OFF_CTRL  = 'h00;
    localparam int unsigned OFF_STAT  = 'h04;
    localparam int unsigned OFF_ADDR  = 'h18;
    localparam int unsigned OFF_LEN   = 'h28;

    localparam int BIT_RUN    = 0;
    localparam int BIT_SRST   = 2;
    localparam int BIT_HALTED = 0;
    localparam int BIT_DONE   = 12;

    typedef enum logic [1:0] {
        CH_HALTED,
        CH_RUNNING,
        CH_STOPPING,
        CH_RESETTING
    } chan_state_e;

    typedef enum logic [1:0] {
        TX_IDLE,
        TX_FETCH,
        TX_LOAD,
        TX_SEND
    } tx_state_e;

    typedef enum logic {
        RX_IDLE,
        RX_ACCEPT
    } rx_state_e;

endpackage

// File: rtl/sdma_chan_ctrl.sv
module sdma_chan_ctrl
    import sdma_pkg::*;
#(
    parameter int AW         = 32,
    parameter int LW         = 16,
    parameter int RST_CYCLES = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_ctrl,
    input  logic          wr_stat,
    input  logic          wr_addr,
    input  logic          wr_len,
    input  logic [31:0]   wdata,
    input  logic          dp_busy,
    input  logic          dp_done,
    output logic [31:0]   ctrl_rd,
    output logic [31:0]   stat_rd,
    output logic [AW-1:0] addr_q,
    output logic [LW-1:0] len_q,
    output logic          launch,
    output logic          chan_rst
);

    localparam int CW = $clog2(RST_CYCLES + 1);

    chan_state_e st, st_n;
    logic [CW-1:0] cnt;
    logic          done_q;
    logic          srst_req, run_req, stop_req;

    assign srst_req = wr_ctrl && wdata[BIT_SRST];
    assign run_req  = wr_ctrl && !wdata[BIT_SRST] && wdata[BIT_RUN];
    assign stop_req = wr_ctrl && !wdata[BIT_SRST] && !wdata[BIT_RUN];

    always_comb begin
        st_n = st;
        unique case (st)
            CH_HALTED: begin
                if (srst_req)     st_n = CH_RESETTING;
                else if (run_req) st_n = CH_RUNNING;
            end
            CH_RUNNING: begin
                if (srst_req)      st_n = CH_RESETTING;
                else if (stop_req) st_n = dp_busy ? CH_STOPPING : CH_HALTED;
            end
            CH_STOPPING: begin
                if (srst_req)      st_n = CH_RESETTING;
                else if (run_req)  st_n = CH_RUNNING;
                else if (!dp_busy) st_n = CH_HALTED;
            end
            CH_RESETTING: begin
                if (cnt == '0) st_n = CH_HALTED;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st  <= CH_HALTED;
            cnt <= '0;
        end else begin
            st <= st_n;
            if (st != CH_RESETTING && st_n == CH_RESETTING)
                cnt <= CW'(RST_CYCLES - 1);
            else if (st == CH_RESETTING && cnt != '0)
                cnt <= cnt - 1'b1;
        end
    end

    assign chan_rst = (st == CH_RESETTING);
    assign launch   = wr_len && (st == CH_RUNNING) && !dp_busy && (wdata[LW-1:2] != '0);

    always_ff @(posedge clk) begin
        if (!rst_n || chan_rst) begin
            addr_q <= '0;
            len_q  <= '0;
            done_q <= 1'b0;
        end else begin
            if (wr_addr) addr_q <= wdata[AW-1:0];
            if (launch)  len_q  <= wdata[LW-1:0];
            if (dp_done)                          done_q <= 1'b1;
            else if (wr_stat && wdata[BIT_DONE])  done_q <= 1'b0;
        end
    end

    always_comb begin
        ctrl_rd             = '0;
        ctrl_rd[BIT_RUN]    = (st == CH_RUNNING);
        ctrl_rd[BIT_SRST]   = (st == CH_RESETTING);
        stat_rd             = '0;
        stat_rd[BIT_HALTED] = (st == CH_HALTED) || (st == CH_RESETTING);
        stat_rd[BIT_DONE]   = done_q;
    end

endmodule

// File: rtl/sdma_mm2s.sv
module sdma_mm2s
    import sdma_pkg::*;
#(
    parameter int AW = 32,
    parameter int LW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          chan_rst,
    input  logic          launch,
    input  logic [AW-3:0] start_word,
    input  logic [LW-3:0] start_count,
    output logic          busy,
    output logic          done,
    output logic          mem_rd_en,
    output logic [AW-3:0] mem_rd_addr,
    input  logic [31:0]   mem_rd_data,
    output logic          m_tvalid,
    input  logic          m_tready,
    output logic [31:0]   m_tdata,
    output logic          m_tlast,
    output logic [3:0]    m_tkeep
);

    tx_state_e     st, st_n;
    logic [AW-3:0] ptr;
    logic [LW-3:0] left;
    logic [31:0]   data_q;
    logic          final_word;

    assign final_word = (left == (LW-2)'(1));

    always_comb begin
        st_n = st;
        unique case (st)
            TX_IDLE:  if (launch) st_n = TX_FETCH;
            TX_FETCH: st_n = TX_LOAD;
            TX_LOAD:  st_n = TX_SEND;
            TX_SEND:  if (m_tready) st_n = final_word ? TX_IDLE : TX_FETCH;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n || chan_rst) begin
            st     <= TX_IDLE;
            ptr    <= '0;
            left   <= '0;
            data_q <= '0;
        end else begin
            st <= st_n;
            if (st == TX_IDLE && launch) begin
                ptr  <= start_word;
                left <= start_count;
            end
            if (st == TX_LOAD) data_q <= mem_rd_data;
            if (st == TX_SEND && m_tready) begin
                ptr  <= ptr + 1'b1;
                left <= left - 1'b1;
            end
        end
    end

    always_comb begin
        busy        = (st != TX_IDLE);
        mem_rd_en   = (st == TX_FETCH);
        mem_rd_addr = ptr;
        m_tvalid    = (st == TX_SEND);
        m_tdata     = data_q;
        m_tlast     = (st == TX_SEND) && final_word;
        m_tkeep     = 4'hF;
        done        = (st == TX_SEND) && m_tready && final_word;
    end

endmodule

// File: rtl/sdma_s2mm.sv
module sdma_s2mm
    import sdma_pkg::*;
#(
    parameter int AW = 32,
    parameter int LW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          chan_rst,
    input  logic          launch,
    input  logic [AW-3:0] start_word,
    input  logic [LW-3:0] start_count,
    output logic          busy,
    output logic          done,
    output logic          mem_wr_en,
    output logic [AW-3:0] mem_wr_addr,
    output logic [31:0]   mem_wr_data,
    input  logic          s_tvalid,
    output logic          s_tready,
    input  logic [31:0]   s_tdata,
    input  logic          s_tlast
);

    rx_state_e     st, st_n;
    logic [AW-3:0] ptr;
    logic [LW-3:0] left;
    logic          beat, ending;

    assign beat   = (st == RX_ACCEPT) && s_tvalid;
    assign ending = beat && (s_tlast || left == (LW-2)'(1));

    always_comb begin
        st_n = st;
        unique case (st)
            RX_IDLE:   if (launch) st_n = RX_ACCEPT;
            RX_ACCEPT: if (ending) st_n = RX_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n || chan_rst) begin
            st   <= RX_IDLE;
            ptr  <= '0;
            left <= '0;
        end else begin
            st <= st_n;
            if (st == RX_IDLE && launch) begin
                ptr  <= start_word;
                left <= start_count;
            end else if (beat) begin
                ptr  <= ptr + 1'b1;
                left <= left - 1'b1;
            end
        end
    end

    always_comb begin
        busy        = (st != RX_IDLE);
        s_tready    = (st == RX_ACCEPT);
        mem_wr_en   = beat;
        mem_wr_addr = ptr;
        mem_wr_data = s_tdata;
        done        = ending;
    end

endmodule

// File: rtl/sdma_engine.sv
module sdma_engine
    import sdma_pkg::*;
#(
    parameter int AW         = 32,
    parameter int LW         = 16,
    parameter int REG_AW     = 8,
    parameter int RST_CYCLES = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_valid,
    input  logic              cfg_write,
    input  logic [REG_AW-1:0] cfg_addr,
    input  logic [31:0]       cfg_wdata,
    output logic [31:0]       cfg_rdata,
    output logic              cfg_rvalid,
    output logic              mem_rd_en,
    output logic [AW-3:0]     mem_rd_addr,
    input  logic [31:0]       mem_rd_data,
    output logic              mem_wr_en,
    output logic [AW-3:0]     mem_wr_addr,
    output logic [31:0]       mem_wr_data,
    output logic              m_tvalid,
    input  logic              m_tready,
    output logic [31:0]       m_tdata,
    output logic              m_tlast,
    output logic [3:0]        m_tkeep,
    input  logic              s_tvalid,
    output logic              s_tready,
    input  logic [31:0]       s_tdata,
    input  logic              s_tlast
);

    logic [NUM_CH-1:0] dp_busy, dp_done, launch, chan_rst;
    logic [31:0]       ctrl_rd [NUM_CH];
    logic [31:0]       stat_rd [NUM_CH];
    logic [AW-1:0]     addr_q  [NUM_CH];
    logic [LW-1:0]     len_q   [NUM_CH];
    logic              wr_any;
    logic [31:0]       rd_mux;

    assign wr_any = cfg_valid && cfg_write;

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
        localparam logic [REG_AW-1:0] A_CTRL = REG_AW'(ch * CH_STRIDE + OFF_CTRL);
        localparam logic [REG_AW-1:0] A_STAT = REG_AW'(ch * CH_STRIDE + OFF_STAT);
        localparam logic [REG_AW-1:0] A_ADDR = REG_AW'(ch * CH_STRIDE + OFF_ADDR);
        localparam logic [REG_AW-1:0] A_LEN  = REG_AW'(ch * CH_STRIDE + OFF_LEN);

        sdma_chan_ctrl #(.AW(AW), .LW(LW), .RST_CYCLES(RST_CYCLES)) u_ctrl (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_ctrl  (wr_any && cfg_addr == A_CTRL),
            .wr_stat  (wr_any && cfg_addr == A_STAT),
            .wr_addr  (wr_any && cfg_addr == A_ADDR),
            .wr_len   (wr_any && cfg_addr == A_LEN),
            .wdata    (cfg_wdata),
            .dp_busy  (dp_busy[ch]),
            .dp_done  (dp_done[ch]),
            .ctrl_rd  (ctrl_rd[ch]),
            .stat_rd  (stat_rd[ch]),
            .addr_q   (addr_q[ch]),
            .len_q    (len_q[ch]),
            .launch   (launch[ch]),
            .chan_rst (chan_rst[ch])
        );
    end

    sdma_mm2s #(.AW(AW), .LW(LW)) u_send (
        .clk         (clk),
        .rst_n       (rst_n),
        .chan_rst    (chan_rst[CH_SEND]),
        .launch      (launch[CH_SEND]),
        .start_word  (addr_q[CH_SEND][AW-1:2]),
        .start_count (cfg_wdata[LW-1:2]),
        .busy        (dp_busy[CH_SEND]),
        .done        (dp_done[CH_SEND]),
        .mem_rd_en   (mem_rd_en),
        .mem_rd_addr (mem_rd_addr),
        .mem_rd_data (mem_rd_data),
        .m_tvalid    (m_tvalid),
        .m_tready    (m_tready),
        .m_tdata     (m_tdata),
        .m_tlast     (m_tlast),
        .m_tkeep     (m_tkeep)
    );

    sdma_s2mm #(.AW(AW), .LW(LW)) u_recv (
        .clk         (clk),
        .rst_n       (rst_n),
        .chan_rst    (chan_rst[CH_RECV]),
        .launch      (launch[CH_RECV]),
        .start_word  (addr_q[CH_RECV][AW-1:2]),
        .start_count (cfg_wdata[LW-1:2]),
        .busy        (dp_busy[CH_RECV]),
        .done        (dp_done[CH_RECV]),
        .mem_wr_en   (mem_wr_en),
        .mem_wr_addr (mem_wr_addr),
        .mem_wr_data (mem_wr_data),
        .s_tvalid    (s_tvalid),
        .s_tready    (s_tready),
        .s_tdata     (s_tdata),
        .s_tlast     (s_tlast)
    );

    always_comb begin
        rd_mux = '0;
        for (int ch = 0; ch < NUM_CH; ch++) begin
            if (cfg_addr == REG_AW'(ch * CH_STRIDE + OFF_CTRL)) rd_mux = ctrl_rd[ch];
            if (cfg_addr == REG_AW'(ch * CH_STRIDE + OFF_STAT)) rd_mux = stat_rd[ch];
            if (cfg_addr == REG_AW'(ch * CH_STRIDE + OFF_ADDR)) rd_mux = 32'(addr_q[ch]);
            if (cfg_addr == REG_AW'(ch * CH_STRIDE + OFF_LEN))  rd_mux = 32'(len_q[ch]);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_rdata  <= '0;
            cfg_rvalid <= 1'b0;
        end else begin
            cfg_rvalid <= cfg_valid && !cfg_write;
            if (cfg_valid && !cfg_write) cfg_rdata <= rd_mux;
        end
    end

endmodule

// File: rtl/sdma_checker.sv
module sdma_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        cfg_valid,
    input logic        cfg_write,
    input logic        cfg_rvalid,
    input logic        mem_rd_en,
    input logic        m_tvalid,
    input logic        m_tready,
    input logic        m_tlast,
    input logic [31:0] m_tdata,
    input logic        s_tvalid,
    input logic        s_tready,
    input logic        s_tlast
);

    assert_read_strobe_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_valid && !cfg_write |=> cfg_rvalid);

    assert_no_stray_strobe_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(cfg_valid && !cfg_write) |=> !cfg_rvalid);

    assert_stall_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        m_tvalid && !m_tready |=> m_tvalid && $stable(m_tdata) && $stable(m_tlast));

    assert_valid_drop_after_last_R7: assert property (@(posedge clk) disable iff (!rst_n)
        m_tvalid && m_tready && m_tlast |=> !m_tvalid);

    assert_fetch_not_during_offer_R7: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_en |-> !m_tvalid);

    assert_ready_drop_after_last_R8: assert property (@(posedge clk) disable iff (!rst_n)
        s_tvalid && s_tready && s_tlast |=> !s_tready);

endmodule

bind sdma_engine sdma_checker u_chk (.*);

// File: tb/tb_sdma_engine.sv
module tb_sdma_engine;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_valid = 1'b0, cfg_write = 1'b0;
    logic [7:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        cfg_rvalid;
    logic        mem_rd_en, mem_wr_en;
    logic [29:0] mem_rd_addr, mem_wr_addr;
    logic [31:0] mem_rd_data = '0, mem_wr_data;
    logic        m_tvalid, m_tlast;
    logic        m_tready = 1'b0;
    logic [31:0] m_tdata;
    logic [3:0]  m_tkeep;
    logic        s_tvalid = 1'b0, s_tlast = 1'b0, s_tready;
    logic [31:0] s_tdata = '0;

    int n_tests = 0, n_fail = 0;
    logic [31:0] mem [256];
    logic [31:0] tx_data [64];
    logic        tx_last [64];
    int          tx_n = 0;
    int          keep_bad = 0;
    logic        rdy_force = 1'b1, rdy_val = 1'b0;

    always #10 clk = ~clk;

    sdma_engine dut (
        .clk(clk), .rst_n(rst_n),
        .cfg_valid(cfg_valid), .cfg_write(cfg_write), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .cfg_rvalid(cfg_rvalid),
        .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr), .mem_rd_data(mem_rd_data),
        .mem_wr_en(mem_wr_en), .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data),
        .m_tvalid(m_tvalid), .m_tready(m_tready), .m_tdata(m_tdata),
        .m_tlast(m_tlast), .m_tkeep(m_tkeep),
        .s_tvalid(s_tvalid), .s_tready(s_tready), .s_tdata(s_tdata), .s_tlast(s_tlast)
    );

    always @(posedge clk) begin
        if (mem_rd_en) mem_rd_data <= mem[mem_rd_addr[7:0]];
        if (mem_wr_en) mem[mem_wr_addr[7:0]] <= mem_wr_data;
        if (m_tvalid && m_tready && tx_n < 64) begin
            tx_data[tx_n] = m_tdata;
            tx_last[tx_n] = m_tlast;
            if (m_tkeep != 4'hF) keep_bad = keep_bad + 1;
            tx_n = tx_n + 1;
        end
    end

    always @(negedge clk) m_tready <= rdy_force ? rdy_val : ($urandom_range(0, 3) != 0);

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
        end
    endtask

    task automatic reg_wr(input logic [7:0] a, input logic [31:0] d);
        cfg_valid = 1'b1; cfg_write = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_valid = 1'b0; cfg_write = 1'b0;
    endtask

    task automatic reg_rd(input logic [7:0] a, output logic [31:0] d);
        cfg_valid = 1'b1; cfg_write = 1'b0; cfg_addr = a;
        @(negedge clk);
        cfg_valid = 1'b0;
        d = cfg_rdata;
    endtask

    task automatic expect_reg(input string tag, input logic [7:0] a, input logic [31:0] exp);
        logic [31:0] v;
        reg_rd(a, v);
        check(tag, v, exp);
    endtask

    task automatic push(input logic [31:0] d, input logic last);
        repeat ($urandom_range(0, 2)) @(negedge clk);
        s_tvalid = 1'b1; s_tdata = d; s_tlast = last;
        for (int i = 0; i < 200; i++) begin
            logic seen;
            seen = s_tready;
            @(negedge clk);
            if (seen) break;
        end
        s_tvalid = 1'b0; s_tlast = 1'b0;
    endtask

    task automatic wait_tx(input int n);
        for (int i = 0; i < 2000 && tx_n < n; i++) @(negedge clk);
    endtask

    task automatic send_run(input int word, input int words, input string tag);
        for (int i = 0; i < words; i++) mem[word + i] = $urandom;
        tx_n = 0;
        reg_wr(8'h18, word * 4);
        reg_wr(8'h28, words * 4);
        wait_tx(words);
        repeat (8) @(negedge clk);
        check({tag, " word count"}, tx_n, words);
        for (int i = 0; i < words; i++) begin
            check({tag, " data"}, tx_data[i], mem[word + i]);
            check({tag, " tlast position"}, {31'b0, tx_last[i]}, {31'b0, i == words - 1});
        end
        check({tag, " tkeep all ones"}, keep_bad, 0);
        expect_reg({tag, " done flag set (R9)"}, 8'h04, 32'h1000);
        reg_wr(8'h04, 32'h1000);
        expect_reg({tag, " done cleared by write-one (R9)"}, 8'h04, 32'h0);
    endtask

    initial begin
        logic [31:0] exp_mem [8];
        void'($urandom(32'd20240607));
        for (int i = 0; i < 256; i++) mem[i] = 32'hDEAD_0000 | i;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset values
        expect_reg("R1 send status", 8'h04, 32'h1);
        expect_reg("R1 recv status", 8'h34, 32'h1);
        expect_reg("R1 send control", 8'h00, 32'h0);
        expect_reg("R1 recv length", 8'h58, 32'h0);
        check("R1 m_tvalid low", {31'b0, m_tvalid}, 32'h0);
        check("R1 s_tready low", {31'b0, s_tready}, 32'h0);

        // R6: length write while halted ignored
        reg_wr(8'h28, 32'd16);
        repeat (6) @(negedge clk);
        check("R6 halted length write no stream", {31'b0, m_tvalid}, 32'h0);
        expect_reg("R6 halted length unchanged", 8'h28, 32'h0);
        expect_reg("R2 unmapped offset reads zero", 8'h08, 32'h0);

        // R3: run both channels
        reg_wr(8'h00, 32'h1);
        reg_wr(8'h30, 32'h1);
        expect_reg("R3 send halted clears", 8'h04, 32'h0);
        expect_reg("R3 run bit reads one", 8'h30, 32'h1);
        reg_wr(8'h48, 32'h0000_0ABC);
        expect_reg("R2 recv address readback", 8'h48, 32'h0000_0ABC);

        // R5 R7: directed send
        rdy_force = 1'b0;
        send_run(16, 8, "R7 directed send");

        // R6: length write while busy ignored
        rdy_force = 1'b1; rdy_val = 1'b0;
        for (int i = 0; i < 4; i++) mem[32 + i] = $urandom;
        tx_n = 0;
        reg_wr(8'h18, 32 * 4);
        reg_wr(8'h28, 32'd16);
        reg_wr(8'h28, 32'd40);
        expect_reg("R6 busy length unchanged", 8'h28, 32'd16);
        rdy_force = 1'b0;
        wait_tx(4);
        repeat (10) @(negedge clk);
        check("R6 busy write no extra words", tx_n, 4);
        reg_wr(8'h04, 32'h1000);

        // R5 R7: random sends
        for (int k = 0; k < 4; k++) begin
            int w, n;
            w = $urandom_range(40, 200);
            n = $urandom_range(1, 12);
            send_run(w, n, "R5 random send");
        end

        // R8: receive stops at programmed count
        mem[70] = 32'h5A5A_0070;
        reg_wr(8'h48, 64 * 4);
        reg_wr(8'h58, 32'd24);
        for (int i = 0; i < 6; i++) begin
            exp_mem[i] = $urandom;
            push(exp_mem[i], 1'b0);
        end
        @(negedge clk);
        for (int i = 0; i < 6; i++) check("R8 count-limited word", mem[64 + i], exp_mem[i]);
        check("R8 word past count untouched", mem[70], 32'h5A5A_0070);
        check("R8 ready low after count", {31'b0, s_tready}, 32'h0);
        expect_reg("R9 recv done set", 8'h34, 32'h1000);
        reg_wr(8'h34, 32'h1000);

        // R8: early tlast
        mem[83] = 32'h5A5A_0083;
        reg_wr(8'h48, 80 * 4);
        reg_wr(8'h58, 32'd32);
        for (int i = 0; i < 3; i++) begin
            exp_mem[i] = $urandom;
            push(exp_mem[i], i == 2);
        end
        @(negedge clk);
        for (int i = 0; i < 3; i++) check("R8 early tlast word", mem[80 + i], exp_mem[i]);
        check("R8 word after tlast untouched", mem[83], 32'h5A5A_0083);
        check("R8 ready low after tlast", {31'b0, s_tready}, 32'h0);
        expect_reg("R9 done after early tlast", 8'h34, 32'h1000);
        reg_wr(8'h34, 32'h1000);
        expect_reg("R9 recv done cleared", 8'h34, 32'h0);

        // R9: completion and clear write on the same edge
        reg_wr(8'h48, 96 * 4);
        reg_wr(8'h58, 32'd8);
        push(32'h1111_2222, 1'b0);
        check("R9 ready before final word", {31'b0, s_tready}, 32'h1);
        s_tvalid = 1'b1; s_tdata = 32'h3333_4444; s_tlast = 1'b1;
        cfg_valid = 1'b1; cfg_write = 1'b1; cfg_addr = 8'h34; cfg_wdata = 32'h1000;
        @(negedge clk);
        s_tvalid = 1'b0; s_tlast = 1'b0; cfg_valid = 1'b0; cfg_write = 1'b0;
        expect_reg("R9 set wins over same-cycle clear", 8'h34, 32'h1000);
        check("R8 same-cycle final word stored", mem[97], 32'h3333_4444);
        reg_wr(8'h34, 32'h1000);
        expect_reg("R9 later clear takes effect", 8'h34, 32'h0);

        // R4: soft reset of the send channel
        reg_wr(8'h18, 32'h0000_0100);
        reg_wr(8'h00, 32'h4);
        expect_reg("R4 reset bit reads one", 8'h00, 32'h4);
        repeat (12) @(negedge clk);
        expect_reg("R4 reset bit self-clears", 8'h00, 32'h0);
        expect_reg("R4 channel halted after reset", 8'h04, 32'h1);
        expect_reg("R4 address cleared", 8'h18, 32'h0);
        expect_reg("R4 length cleared", 8'h28, 32'h0);
        expect_reg("R4 other channel keeps running", 8'h34, 32'h0);

        // R3: stop an idle channel
        reg_wr(8'h30, 32'h0);
        expect_reg("R3 stop sets halted", 8'h34, 32'h1);
        expect_reg("R3 run bit reads zero", 8'h30, 32'h0);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL R1-R9 watchdog actual=hung expected=completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule